// File: doc/BRIEF.md
# Ring Descriptor DMA Channel

This block is one DMA channel that follows a ring of linked descriptors in memory. It moves 16-bit audio halfwords between memory and its own slice of a sample FIFO. Each descriptor is three 32-bit words at consecutive addresses:

- a buffer address;
- a count word, holding the byte count in bits 13:0 and an interrupt-enable flag in bit 29;
- the address of the next descriptor.

Software builds the ring so that the last descriptor points back to the first. The channel then circulates until it is stopped.

The host loads the descriptor pointer and then writes a control word. The control word sets the direction, the byte order, the FIFO partition and the threshold, and sets the active bit. In transmit mode the channel refills the FIFO from memory, and a peripheral pops samples from it. In receive mode the peripheral pushes samples, and the channel drains them to memory. A descriptor whose interrupt-enable flag is set raises a sticky interrupt when its block completes. Reading the control word acknowledges that interrupt.

Memory is reached through a request/grant port. The address and the write data stay stable until grant. On the grant cycle, `mem_rdata` carries the read word; for a data read, the halfword is in bits 15:0.

Top module: `ring_dma_channel`

## Requirements
- R1: After reset the channel is idle. `mem_req` and `irq` are 0, `fifo_level` is 0, and the control, descriptor-pointer and buffer-pointer registers all read 0.
- R2: Host register map: `host_addr` 0 is the control word, 1 is the descriptor pointer and 2 is the buffer pointer. Setting control bit 4 (active) while idle starts the channel. It then reads the descriptor at the descriptor pointer as three words in order (+0, +4, +8), and each read holds its address until granted.
- R3: In transmit mode (control bit 2 clear), the channel reads halfwords from consecutive buffer addresses. It does so only while the FIFO level is at or below the high-water mark (control bits 15:8, in halfwords) and below capacity. With no pops, the level therefore settles at mark+1.
- R4: In receive mode (control bit 2 set), the channel writes the FIFO head to memory only while the level is at or above the mark and non-zero. The writes go to consecutive buffer addresses.
- R5: FIFO capacity is (end − begin) × 4 halfwords, where begin is control bits 23:16 and end is bits 31:24, both in doublewords. The capacity is limited to the storage depth. A peripheral push into a full FIFO is dropped.
- R6: Control bit 1 (little-endian) swaps the two bytes of every halfword as it passes between memory and the FIFO, in both directions.
- R7: When a descriptor's byte count is used up, the block completes. `irq` is set one cycle later only if that descriptor's count word has bit 29 set.
- R8: A host read of the control word returns the interrupt flag in bit 0 and clears it on the next cycle. A completion in the same cycle as that read leaves the flag set.
- R9: When a block completes, the next-descriptor word becomes the descriptor pointer and the fetch starts there. A ring therefore wraps from its last descriptor back to its first.
- R10: Any write of the control word empties the FIFO. A write with bit 4 clear returns the channel to idle, so `mem_req` is 0 on the next cycle and control bit 4 reads 0.
- R11: During a run, the buffer pointer reads the address of the next halfword to move and advances by 2 per granted beat. The descriptor pointer reads the descriptor currently in use.
- R12: `per_pop` has no effect in receive mode, and `per_push` has no effect in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears the interrupt on a control read) |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Sticky block-completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a halfword write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write halfword |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| mem_rdata | input | 32 | Memory read word, valid with grant |
| per_push | input | 1 | Peripheral pushes a sample (receive) |
| per_wdata | input | 16 | Pushed sample |
| per_pop | input | 1 | Peripheral pops a sample (transmit) |
| per_rdata | output | 16 | FIFO head sample |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Halfwords held in the FIFO |

## Verification
The hardest case to reach from the ports is a completion that lands in the same cycle as a control-word read. The acknowledge must lose to the new completion in that cycle. The stimulus makes this cycle predictable by starting the channel on a descriptor with a zero byte count and interrupt enable set, with the grant held on. The fetch then takes exactly three granted cycles, and the completion comes in the fourth cycle after the start, where the bench places the read. A second case is the capacity limit in receive mode. To reach it, the bench withholds grant so that the drain stalls while samples are pushed past the partition size.

// File: rtl/ring_dma_channel.sv
module ring_dma_channel #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 14,
  parameter int IE_BIT     = 29
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_wr,
  input  logic                              host_rd,
  input  logic [1:0]                        host_addr,
  input  logic [31:0]                       host_wdata,
  output logic [31:0]                       host_rdata,
  output logic                              irq,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [31:0]                       mem_addr,
  output logic [15:0]                       mem_wdata,
  input  logic                              mem_gnt,
  input  logic [31:0]                       mem_rdata,
  input  logic                              per_push,
  input  logic [15:0]                       per_wdata,
  input  logic                              per_pop,
  output logic [15:0]                       per_rdata,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_level
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);
  localparam int PW = $clog2(FIFO_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CNT, S_NEXT, S_XFER} st_t;
  st_t st;

  logic              le_q, rx_q, rt_q, ie_q, irq_q;
  logic [7:0]        hw_q, beg_q, end_q;
  logic [31:0]       dptr_q, bptr_q, nxt_q;
  logic [CNT_W-1:0]  rem_q;
  logic [15:0]       fifo_q [FIFO_DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [LW-1:0]     lvl_q, cap;
  logic [9:0]        span;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign span = (end_q > beg_q) ? {end_q - beg_q, 2'b00} : '0;
  assign cap  = (span > 10'(FIFO_DEPTH)) ? LW'(FIFO_DEPTH) : LW'(span);

  logic ctrl_wr, ctrl_rd, xfer, blk_done, want, beat, push, pop;
  logic [15:0] head, push_d;

  assign ctrl_wr  = host_wr && host_addr == 2'd0;
  assign ctrl_rd  = host_rd && host_addr == 2'd0;
  assign xfer     = st == S_XFER;
  assign blk_done = xfer && rem_q < CNT_W'(2);
  assign want     = xfer && !blk_done &&
                    (rx_q ? (32'(lvl_q) >= 32'(hw_q) && lvl_q != '0)
                          : (32'(lvl_q) <= 32'(hw_q) && lvl_q < cap));
  assign beat     = want && mem_gnt;

  assign mem_req  = (st inside {S_ADDR, S_CNT, S_NEXT}) || want;
  assign mem_we   = xfer && rx_q;
  always_comb begin
    case (st)
      S_CNT:   mem_addr = dptr_q + 32'd4;
      S_NEXT:  mem_addr = dptr_q + 32'd8;
      S_XFER:  mem_addr = bptr_q;
      default: mem_addr = dptr_q;
    endcase
  end

  assign head      = fifo_q[rp_q];
  assign per_rdata = head;
  assign mem_wdata = le_q ? swap16(head) : head;
  assign push      = rx_q ? (per_push && lvl_q < cap) : beat;
  assign pop       = rx_q ? beat : (per_pop && lvl_q != '0);
  assign push_d    = rx_q ? per_wdata : (le_q ? swap16(mem_rdata[15:0]) : mem_rdata[15:0]);

  always_ff @(posedge clk) begin
    if (push && !ctrl_wr) fifo_q[wp_q] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_wr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      lvl_q <= lvl_q + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {le_q, rx_q, rt_q, ie_q} <= '0;
      {hw_q, beg_q, end_q} <= '0;
      dptr_q <= '0;
      bptr_q <= '0;
      nxt_q  <= '0;
      rem_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        le_q  <= host_wdata[1];
        rx_q  <= host_wdata[2];
        rt_q  <= host_wdata[3];
        hw_q  <= host_wdata[15:8];
        beg_q <= host_wdata[23:16];
        end_q <= host_wdata[31:24];
        if (!host_wdata[4])     st <= S_IDLE;
        else if (st == S_IDLE)  st <= S_ADDR;
      end else begin
        case (st)
          S_ADDR: if (mem_gnt) begin bptr_q <= mem_rdata; st <= S_CNT; end
          S_CNT:  if (mem_gnt) begin
                    rem_q <= mem_rdata[CNT_W-1:0];
                    ie_q  <= mem_rdata[IE_BIT];
                    st    <= S_NEXT;
                  end
          S_NEXT: if (mem_gnt) begin nxt_q <= mem_rdata; st <= S_XFER; end
          S_XFER: if (blk_done) begin
                    dptr_q <= nxt_q;
                    st     <= S_ADDR;
                  end else if (beat) begin
                    bptr_q <= bptr_q + 32'd2;
                    rem_q  <= rem_q - CNT_W'(2);
                  end
          default: ;
        endcase
      end
      if (host_wr && host_addr == 2'd1) dptr_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  irq_q <= 1'b0;
    else if (blk_done && ie_q)   irq_q <= 1'b1;
    else if (ctrl_rd)            irq_q <= 1'b0;
  end
  assign irq = irq_q;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = {end_q, beg_q, hw_q, 3'b000, st != S_IDLE, rt_q, rx_q, le_q, irq_q};
      2'd1:    host_rdata = dptr_q;
      2'd2:    host_rdata = bptr_q;
      default: host_rdata = '0;
    endcase
  end
  assign fifo_level = lvl_q;

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !host_wdata[4] |=> !mem_req && fifo_level == '0);
  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && ie_q |=> irq);
  // R8
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd && !(blk_done && ie_q) |=> !irq);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= FIFO_DEPTH);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !host_wr |=> mem_req && $stable(mem_addr));
  // R11
  bptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !host_wr |=> bptr_q == $past(bptr_q) + 32'd2);
endmodule

// File: tb/ring_dma_channel_tb.sv
module ring_dma_channel_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic irq, mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_rdata;
  logic [15:0] mem_wdata, per_rdata;
  logic per_push = 0, per_pop = 0;
  logic [15:0] per_wdata = 0;
  logic [4:0] fifo_level;
  logic gnt_en = 1'b1;
  int nchk = 0, nfail = 0;

  logic [31:0] dtab [32];
  logic [31:0] rlog [64];
  logic [31:0] wlog_a [64];
  logic [15:0] wlog_d [64];
  int rcnt = 0, wcnt = 0;
  localparam logic [31:0] IE = 32'h2000_0000;

  always #5 clk = ~clk;

  ring_dma_channel u_dut (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .irq, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rdata,
    .per_push, .per_wdata, .per_pop, .per_rdata, .fifo_level);

  assign mem_gnt   = mem_req && gnt_en;
  assign mem_rdata = (mem_addr < 32'h100) ? dtab[mem_addr[6:2]]
                                          : {16'h0, mem_addr[15:0] ^ 16'h1234};

  always @(posedge clk) begin
    if (mem_req && mem_gnt && !mem_we && rcnt < 64) begin rlog[rcnt] = mem_addr; rcnt++; end
    if (mem_req && mem_gnt && mem_we && wcnt < 64) begin
      wlog_a[wcnt] = mem_addr; wlog_d[wcnt] = mem_wdata; wcnt++;
    end
  end

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ 16'h1234;
  endfunction
  function automatic logic [15:0] bsw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
  function automatic logic [31:0] cw(input logic [7:0] e, b, h, input logic act, rx, le);
    return {e, b, h, 3'b000, act, 1'b0, rx, le, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd_ctrl(output logic [31:0] v);
    host_addr = 0; host_rd = 1; #1 v = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    host_addr = a; #1 v = host_rdata;
  endtask

  task automatic pulse_push(input logic [15:0] d);
    per_wdata = d; per_push = 1;
    @(negedge clk);
    per_push = 0;
  endtask

  task automatic pulse_pop();
    per_pop = 1;
    @(negedge clk);
    per_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 0; cyc(5); rst_n = 1; cyc(1);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 level", 32'(fifo_level), 0);
    peek(0, v); chk("R1 ctrl", v, 0);
    peek(1, v); chk("R1 dptr", v, 0);
    peek(2, v); chk("R1 bptr", v, 0);
  endtask

  task automatic t_tx_ring();
    logic [31:0] v;
    logic [31:0] exp_r [14];
    logic [31:0] exp_p [8];
    int base;
    exp_r = '{32'h00, 32'h04, 32'h08, 32'h1000, 32'h1002, 32'h1004, 32'h0C, 32'h10,
              32'h14, 32'h2000, 32'h2002, 32'h18, 32'h1C, 32'h20};
    exp_p = '{32'h1000, 32'h1002, 32'h1004, 32'h2000, 32'h2002, 32'h3000, 32'h1000, 32'h1002};
    base = rcnt;
    wr(1, 32'h0);
    wr(0, cw(8'd2, 8'd0, 8'd4, 1, 0, 0));
    cyc(40);
    for (int i = 0; i < 14; i++) chk($sformatf("R2 read order %0d", i), rlog[base + i], exp_r[i]);
    chk("R3 reads until mark+1", 32'(rcnt - base), 14);
    chk("R3 level settles", 32'(fifo_level), 5);
    peek(2, v); chk("R11 bptr", v, 32'h3000);
    peek(1, v); chk("R11 dptr", v, 32'h18);
    chk("R7 irq after IE block", 32'(irq), 1);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R9 sample %0d", i), 32'(per_rdata), 32'(pat(exp_p[i])));
      pulse_pop();
      cyc(6);
    end
  endtask

  task automatic t_rx();
    logic [31:0] v;
    int base;
    wr(0, 32'h0);
    wr(1, 32'h30);
    base = wcnt;
    wr(0, cw(8'd1, 8'd0, 8'd2, 1, 1, 1));
    cyc(10);
    pulse_push(16'h1122); cyc(3);
    chk("R4 no drain below mark", 32'(wcnt - base), 0);
    pulse_push(16'h3344); cyc(3);
    chk("R4 drain at mark", 32'(wcnt - base), 1);
    chk("R6 swapped write", 32'(wlog_d[base]), 32'h2211);
    chk("R4 write addr", wlog_a[base], 32'h5000);
    chk("R4 level after drain", 32'(fifo_level), 1);
    gnt_en = 0;
    pulse_push(16'h5566); pulse_push(16'h7788); pulse_push(16'h99AA);
    pulse_push(16'hBBCC); pulse_push(16'hDDEE);
    cyc(1);
    chk("R5 capacity limit", 32'(fifo_level), 4);
    gnt_en = 1;
    cyc(6);
    chk("R5 drained count", 32'(wcnt - base), 4);
    chk("R6 write 1", 32'(wlog_d[base + 1]), 32'(bsw(16'h3344)));
    chk("R6 write 2", 32'(wlog_d[base + 2]), 32'(bsw(16'h5566)));
    chk("R6 write 3", 32'(wlog_d[base + 3]), 32'(bsw(16'h7788)));
    chk("R4 write addr 3", wlog_a[base + 3], 32'h5006);
    peek(2, v); chk("R11 rx bptr", v, 32'h5008);
    pulse_pop(); cyc(1);
    chk("R12 pop ignored in rx", 32'(fifo_level), 1);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    gnt_en = 0;
    pulse_push(16'h0F0F);
    chk("R10 pending request", 32'(mem_req), 1);
    wr(0, 32'h0);
    chk("R10 request dropped", 32'(mem_req), 0);
    chk("R10 fifo emptied", 32'(fifo_level), 0);
    peek(0, v); chk("R10 active bit", 32'(v[4]), 0);
    gnt_en = 1;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    rd_ctrl(v); cyc(1);
    chk("R8 ack clears", 32'(irq), 0);
    wr(1, 32'h24);
    wr(0, cw(8'd2, 8'd0, 8'd4, 1, 0, 0));
    cyc(3);
    rd_ctrl(v);
    chk("R8 completion beats ack", 32'(irq), 1);
    cyc(20);
    peek(1, v); chk("R9 next pointer followed", v, 32'h30);
    chk("R3 level desc4", 32'(fifo_level), 5);
    pulse_push(16'hAAAA); cyc(1);
    chk("R12 push ignored in tx", 32'(fifo_level), 5);
    rd_ctrl(v);
    chk("R8 read sees flag", 32'(v[0]), 1);
    cyc(1);
    chk("R8 flag cleared", 32'(irq), 0);
    wr(0, 32'h0);
    wr(1, 32'h3C);
    wr(0, cw(8'd2, 8'd0, 8'd4, 1, 0, 0));
    cyc(20);
    peek(1, v); chk("R7 block without IE done", v, 32'h30);
    chk("R7 no irq without IE", 32'(irq), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) dtab[i] = 0;
    dtab[0]  = 32'h1000; dtab[1]  = IE | 32'd6; dtab[2]  = 32'h0C;
    dtab[3]  = 32'h2000; dtab[4]  = 32'd4;      dtab[5]  = 32'h18;
    dtab[6]  = 32'h3000; dtab[7]  = IE | 32'd2; dtab[8]  = 32'h00;
    dtab[9]  = 32'h4000; dtab[10] = IE;         dtab[11] = 32'h30;
    dtab[12] = 32'h5000; dtab[13] = 32'h3FFE;   dtab[14] = 32'h30;
    dtab[15] = 32'h6000; dtab[16] = 32'd0;      dtab[17] = 32'h30;
    @(negedge clk);
    t_reset();
    t_tx_ring();
    t_rx();
    t_stop();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL all: watchdog expired, got running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule